// File: doc/BRIEF.md
# Dual-Side Inter-Processor Messaging Unit

This block is a mailbox shared by two processors, called side A and side B, that run from one clock. Each side sees a small register window: four transmit words, four receive words, a status word and a control word. A word that one side writes into its transmit slot for channel i shows up in the other side's receive slot for the same channel. A pair of flags follows each slot from one side to the other: the sender sees whether its slot may be written again, and the receiver sees whether fresh data is waiting.

Besides the data channels, each side can ring a doorbell that carries no data. The request bit sits in the ringing side's control word. It moves into a pending bit in the other side's status word, and software clears that pending bit by writing a 1 to it. Each side has one interrupt line, raised by enabled receive-full flags and by an enabled doorbell pending bit. Read data is combinational from the current state and reads 0 whenever the read enable is low.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every transmit-empty flag reads 1. All receive-full flags, pending bits, request bits and enables read 0, and both interrupt lines are low.
- R2: The address map is byte-based and holds only whole words. Transmit channel i is at 0x00+4i and receive channel i is at 0x10+4i. Status is at 0x20 and control is at 0x24. The status word holds transmit-empty at bit 20+i, receive-full at bit 24+i and doorbell pending at bit 31. The control word holds the doorbell interrupt enable at bit 31, the receive-full interrupt enable for channel i at bit 27-i and the doorbell request at bit 19.
- R3: A write to a transmit slot whose transmit-empty flag is 1 stores the data. On the next cycle that flag is 0 and the other side's receive-full flag for the channel is 1.
- R4: A read of a receive slot returns the stored word. If its receive-full flag was 1, the next cycle shows that flag at 0 and the sender's transmit-empty flag at 1 again.
- R5: A write to a transmit slot whose transmit-empty flag is 0 is ignored, so the receiver later reads the earlier word.
- R6: Writing 1 to control bit 19 sets the request. If the other side's pending bit is 0, on the following cycle that pending bit is 1 and the request bit is 0.
- R7: A request raised while the other side's pending bit is 1 stays set until that pending bit is cleared. It then moves across one cycle later.
- R8: Writing a status word with bit 31 set clears the pending bit on the next cycle. Writing bit 31 as 0 leaves it unchanged.
- R9: Writing control bit 19 as 0 does not cancel an outstanding request.
- R10: The interrupt line is high when any receive-full flag is 1 and its enable is 1.
- R11: The interrupt line is high when the doorbell pending bit and its enable are both 1.
- R12: Both directions behave alike: side B's transmit slots and doorbell reach side A exactly as side A's reach side B.
- R13: Reads of transmit slots and of unmapped addresses return 0. Reads with the read enable low return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_we | input | 1 | Side A write enable |
| a_re | input | 1 | Side A read enable |
| a_rdata | output | 32 | Side A read data, valid in the cycle of a_re |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_we | input | 1 | Side B write enable |
| b_re | input | 1 | Side B read enable |
| b_rdata | output | 32 | Side B read data, valid in the cycle of b_re |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench targets four corner cases.

- A second write into a slot that is still full must not replace the first word. A design that overwrote it would lose a message without any sign.
- A doorbell rung while the far pending bit is still set must wait and then arrive exactly once after the clear. A design that dropped it would lose the wake-up, and one that cleared the request early would let software ring again too soon.
- Writing 0 to the pending bit or to the request bit must change nothing. A design that treated those writes as plain stores would clear events that were never handled.
- Both sides issue reads and writes in the same cycles, including a read that drains a slot while the far side tries to refill it. A design that ordered those updates wrongly would leave the two flags of a channel out of step.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 6;
  localparam int unsigned MAX_CH = 4;

  localparam logic [AW-1:0] TX_BASE   = 6'h00;
  localparam logic [AW-1:0] RX_BASE   = 6'h10;
  localparam logic [AW-1:0] STAT_ADDR = 6'h20;
  localparam logic [AW-1:0] CTRL_ADDR = 6'h24;

  localparam int unsigned TXE_LSB   = 20;
  localparam int unsigned RXF_LSB   = 24;
  localparam int unsigned PEND_BIT  = 31;
  localparam int unsigned BIE_BIT   = 31;
  localparam int unsigned RIE_MSB   = 27;
  localparam int unsigned REQ_BIT   = 19;
endpackage

// File: rtl/ipc_mbox_chan.sv
module ipc_mbox_chan
  import ipc_mbox_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic          full,
  output logic [DW-1:0] data
);
  logic          full_n;
  logic          load;
  logic [DW-1:0] data_n;

  always_comb begin
    load   = wr && !full;
    full_n = full ? !rd : wr;
    data_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_n;
      if (load) data <= data_n;
    end
  end
endmodule

// File: rtl/ipc_mbox_bell.sv
module ipc_mbox_bell (
  input  logic clk,
  input  logic rst_n,
  input  logic ring,
  input  logic clr,
  output logic req,
  output logic pend
);
  logic xfer;
  logic req_n;
  logic pend_n;

  always_comb begin
    xfer   = req && !pend;
    req_n  = xfer ? 1'b0 : (req || ring);
    pend_n = xfer ? 1'b1 : (clr ? 1'b0 : pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req  <= 1'b0;
      pend <= 1'b0;
    end else begin
      req  <= req_n;
      pend <= pend_n;
    end
  end
endmodule

// File: rtl/ipc_mbox_port.sv
module ipc_mbox_port
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  input  logic                    we,
  input  logic                    re,
  input  logic [NCH-1:0]          tx_empty,
  input  logic [NCH-1:0]          rx_full,
  input  logic [NCH-1:0][DW-1:0]  rx_data,
  input  logic                    req,
  input  logic                    pend,
  output logic [NCH-1:0]          tx_wr,
  output logic [NCH-1:0]          rx_rd,
  output logic                    ring,
  output logic                    pend_clr,
  output logic [DW-1:0]           rdata,
  output logic                    irq
);
  logic           ctrl_wr;
  logic           bie_q;
  logic           bie_n;
  logic [NCH-1:0] rie_q;
  logic [NCH-1:0] rie_n;
  logic [DW-1:0]  stat_w;
  logic [DW-1:0]  ctrl_w;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_dec
      localparam logic [AW-1:0] TXA = TX_BASE + AW'(4 * gi);
      localparam logic [AW-1:0] RXA = RX_BASE + AW'(4 * gi);
      assign tx_wr[gi] = we && (addr == TXA);
      assign rx_rd[gi] = re && (addr == RXA);
      assign rie_n[gi] = wdata[RIE_MSB - gi];
    end
  endgenerate

  always_comb begin
    ctrl_wr  = we && (addr == CTRL_ADDR);
    ring     = ctrl_wr && wdata[REQ_BIT];
    pend_clr = we && (addr == STAT_ADDR) && wdata[PEND_BIT];
    bie_n    = wdata[BIE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bie_q <= 1'b0;
      rie_q <= '0;
    end else if (ctrl_wr) begin
      bie_q <= bie_n;
      rie_q <= rie_n;
    end
  end

  always_comb begin
    stat_w           = '0;
    ctrl_w           = '0;
    stat_w[PEND_BIT] = pend;
    ctrl_w[BIE_BIT]  = bie_q;
    ctrl_w[REQ_BIT]  = req;
    for (int i = 0; i < NCH; i++) begin
      stat_w[TXE_LSB + i] = tx_empty[i];
      stat_w[RXF_LSB + i] = rx_full[i];
      ctrl_w[RIE_MSB - i] = rie_q[i];
    end
    rdata = '0;
    if (re) begin
      if (addr == STAT_ADDR) rdata = stat_w;
      if (addr == CTRL_ADDR) rdata = ctrl_w;
      for (int i = 0; i < NCH; i++) begin
        if (rx_rd[i]) rdata = rx_data[i];
      end
    end
    irq = (|(rx_full & rie_q)) || (pend && bie_q);
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned NCH = MAX_CH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic          a_we,
  input  logic          a_re,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  input  logic          b_we,
  input  logic          b_re,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  logic [1:0]            rst_pipe;
  logic                  rst_q_n;
  logic [NCH-1:0]        a2b_full, b2a_full;
  logic [NCH-1:0][DW-1:0] a2b_data, b2a_data;
  logic [NCH-1:0]        a_tx_empty, b_tx_empty, a_rx_full, b_rx_full;
  logic [NCH-1:0]        a_tx_wr, b_tx_wr, a_rx_rd, b_rx_rd;
  logic                  a_ring, b_ring, a_pend_clr, b_pend_clr;
  logic                  a_req, b_req, a_pend, b_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  assign a_tx_empty = ~a2b_full;
  assign b_rx_full  = a2b_full;
  assign b_tx_empty = ~b2a_full;
  assign a_rx_full  = b2a_full;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      ipc_mbox_chan u_a2b (
        .clk(clk), .rst_n(rst_q_n), .wr(a_tx_wr[gi]), .rd(b_rx_rd[gi]),
        .wdata(a_wdata), .full(a2b_full[gi]), .data(a2b_data[gi]));
      ipc_mbox_chan u_b2a (
        .clk(clk), .rst_n(rst_q_n), .wr(b_tx_wr[gi]), .rd(a_rx_rd[gi]),
        .wdata(b_wdata), .full(b2a_full[gi]), .data(b2a_data[gi]));
    end
  endgenerate

  ipc_mbox_bell u_bell_a2b (
    .clk(clk), .rst_n(rst_q_n), .ring(a_ring), .clr(b_pend_clr),
    .req(a_req), .pend(b_pend));
  ipc_mbox_bell u_bell_b2a (
    .clk(clk), .rst_n(rst_q_n), .ring(b_ring), .clr(a_pend_clr),
    .req(b_req), .pend(a_pend));

  ipc_mbox_port #(.NCH(NCH)) u_port_a (
    .clk(clk), .rst_n(rst_q_n), .addr(a_addr), .wdata(a_wdata), .we(a_we), .re(a_re),
    .tx_empty(a_tx_empty), .rx_full(a_rx_full), .rx_data(b2a_data),
    .req(a_req), .pend(a_pend), .tx_wr(a_tx_wr), .rx_rd(a_rx_rd),
    .ring(a_ring), .pend_clr(a_pend_clr), .rdata(a_rdata), .irq(a_irq));
  ipc_mbox_port #(.NCH(NCH)) u_port_b (
    .clk(clk), .rst_n(rst_q_n), .addr(b_addr), .wdata(b_wdata), .we(b_we), .re(b_re),
    .tx_empty(b_tx_empty), .rx_full(b_rx_full), .rx_data(a2b_data),
    .req(b_req), .pend(b_pend), .tx_wr(b_tx_wr), .rx_rd(b_rx_rd),
    .ring(b_ring), .pend_clr(b_pend_clr), .rdata(b_rdata), .irq(b_irq));
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned NCH = MAX_CH
) (
  input logic           clk,
  input logic           rst_q_n,
  input logic [AW-1:0]  a_addr,
  input logic [AW-1:0]  b_addr,
  input logic           a_we,
  input logic           a_re,
  input logic           b_we,
  input logic           b_re,
  input logic           a_wd31,
  input logic           b_wd31,
  input logic [NCH-1:0] a_tx_empty,
  input logic [NCH-1:0] b_tx_empty,
  input logic [NCH-1:0] a_rx_full,
  input logic [NCH-1:0] b_rx_full,
  input logic           a_req,
  input logic           b_req,
  input logic           a_pend,
  input logic           b_pend,
  input logic           a_irq,
  input logic           b_irq
);
  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_chk
      localparam logic [AW-1:0] TXA = TX_BASE + AW'(4 * gi);
      localparam logic [AW-1:0] RXA = RX_BASE + AW'(4 * gi);
      AST_A_TX_FILLS: assert property (@(posedge clk) disable iff (!rst_q_n)
        (a_we && a_addr == TXA && a_tx_empty[gi]) |=> (b_rx_full[gi] && !a_tx_empty[gi])); // R3
      AST_B_TX_FILLS: assert property (@(posedge clk) disable iff (!rst_q_n)
        (b_we && b_addr == TXA && b_tx_empty[gi]) |=> (a_rx_full[gi] && !b_tx_empty[gi])); // R12
      AST_B_RX_DRAINS: assert property (@(posedge clk) disable iff (!rst_q_n)
        (b_re && b_addr == RXA && b_rx_full[gi]) |=> (a_tx_empty[gi] && !b_rx_full[gi])); // R4
      AST_A_RX_DRAINS: assert property (@(posedge clk) disable iff (!rst_q_n)
        (a_re && a_addr == RXA && a_rx_full[gi]) |=> (b_tx_empty[gi] && !a_rx_full[gi])); // R12
    end
  endgenerate

  AST_BELL_MOVES_A2B: assert property (@(posedge clk) disable iff (!rst_q_n)
    (a_req && !b_pend) |=> (b_pend && !a_req)); // R6
  AST_BELL_MOVES_B2A: assert property (@(posedge clk) disable iff (!rst_q_n)
    (b_req && !a_pend) |=> (a_pend && !b_req)); // R12
  AST_BELL_HELD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (a_req && b_pend) |=> a_req); // R7
  AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_q_n)
    (b_pend && b_we && b_addr == STAT_ADDR && b_wd31) |=> !b_pend); // R8
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (a_pend && !(a_we && a_addr == STAT_ADDR && a_wd31)) |=> a_pend); // R8
  AST_A_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    a_irq |-> ((|a_rx_full) || a_pend)); // R10
  AST_B_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    b_irq |-> ((|b_rx_full) || b_pend)); // R11
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .a_addr(a_addr), .b_addr(b_addr),
  .a_we(a_we), .a_re(a_re), .b_we(b_we), .b_re(b_re),
  .a_wd31(a_wdata[31]), .b_wd31(b_wdata[31]),
  .a_tx_empty(a_tx_empty), .b_tx_empty(b_tx_empty),
  .a_rx_full(a_rx_full), .b_rx_full(b_rx_full),
  .a_req(a_req), .b_req(b_req), .a_pend(a_pend), .b_pend(b_pend),
  .a_irq(a_irq), .b_irq(b_irq));

// File: tb/tb_ipc_mailbox.sv
module tb_ipc_mailbox;
  localparam logic [5:0] STAT = 6'h20;
  localparam logic [5:0] CTRL = 6'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic        a_we = 1'b0, a_re = 1'b0, b_we = 1'b0, b_re = 1'b0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;

  int ncomp = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic        mfull [2][4];
  logic [31:0] mdata [2][4];
  logic        mreq [2], mpend [2], mgie [2];
  logic        mrie [2][4];

  always #10 clk = ~clk;

  ipc_mailbox dut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_re(a_re),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re),
    .b_rdata(b_rdata), .b_irq(b_irq));

  function automatic logic [5:0] txa(int i); return 6'(4 * i); endfunction
  function automatic logic [5:0] rxa(int i); return 6'(16 + 4 * i); endfunction

  function automatic logic [31:0] mread(int s, logic [5:0] ad);
    logic [31:0] v = '0;
    if (ad == STAT) begin
      v[31] = mpend[s];
      for (int i = 0; i < 4; i++) begin
        v[20 + i] = !mfull[s][i];
        v[24 + i] = mfull[1 - s][i];
      end
    end else if (ad == CTRL) begin
      v[31] = mgie[s];
      v[19] = mreq[s];
      for (int i = 0; i < 4; i++) v[27 - i] = mrie[s][i];
    end else begin
      for (int i = 0; i < 4; i++) if (ad == rxa(i)) v = mdata[1 - s][i];
    end
    return v;
  endfunction

  function automatic logic mirq(int s);
    logic r = mpend[s] && mgie[s];
    for (int i = 0; i < 4; i++) r = r || (mfull[1 - s][i] && mrie[s][i]);
    return r;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 2; s++) begin
      mreq[s] = 0; mpend[s] = 0; mgie[s] = 0;
      for (int i = 0; i < 4; i++) begin
        mfull[s][i] = 0; mdata[s][i] = '0; mrie[s][i] = 0;
      end
    end
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    ncomp++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic        we [2], re [2], w31 [2];
    logic [5:0]  ad [2];
    logic [31:0] wd [2];
    logic        ofull [2][4];
    logic        oreq [2], opend [2];
    we[0] = a_we; re[0] = a_re; ad[0] = a_addr; wd[0] = a_wdata;
    we[1] = b_we; re[1] = b_re; ad[1] = b_addr; wd[1] = b_wdata;
    for (int s = 0; s < 2; s++) begin
      oreq[s] = mreq[s]; opend[s] = mpend[s]; w31[s] = wd[s][31];
      for (int i = 0; i < 4; i++) ofull[s][i] = mfull[s][i];
    end
    for (int s = 0; s < 2; s++) begin
      int o = 1 - s;
      bit xfer, clr, ring;
      for (int i = 0; i < 4; i++) begin
        bit wr = we[s] && ad[s] == txa(i);
        bit rd = re[o] && ad[o] == rxa(i);
        if (wr && !ofull[s][i]) mdata[s][i] = wd[s];
        if (ofull[s][i]) mfull[s][i] = !rd;
        else             mfull[s][i] = wr;
      end
      xfer = oreq[s] && !opend[o];
      clr  = we[o] && ad[o] == STAT && w31[o];
      ring = we[s] && ad[s] == CTRL && wd[s][19];
      if (xfer) begin mpend[o] = 1; mreq[s] = 0; end
      else begin
        if (clr) mpend[o] = 0;
        if (ring) mreq[s] = 1;
      end
      if (we[s] && ad[s] == CTRL) begin
        mgie[s] = wd[s][31];
        for (int i = 0; i < 4; i++) mrie[s][i] = wd[s][27 - i];
      end
    end
  endtask

  // One clock: compare outputs mid-cycle, advance the model at the edge, return to idle.
  task automatic tick(string tag);
    @(negedge clk);
    #1;
    check(tag, "a_rdata", a_rdata, a_re ? mread(0, a_addr) : 32'h0);
    check(tag, "b_rdata", b_rdata, b_re ? mread(1, b_addr) : 32'h0);
    check(tag, "a_irq", {31'h0, a_irq}, {31'h0, mirq(0)});
    check(tag, "b_irq", {31'h0, b_irq}, {31'h0, mirq(1)});
    @(posedge clk);
    if (rst_n) model_step();
    #1;
    a_we = 0; a_re = 0; b_we = 0; b_re = 0;
  endtask

  task automatic op(int s, bit we, bit re, logic [5:0] ad, logic [31:0] wd);
    if (s == 0) begin a_we = we; a_re = re; a_addr = ad; a_wdata = wd; end
    else        begin b_we = we; b_re = re; b_addr = ad; b_wdata = wd; end
  endtask

  task automatic wr(int s, logic [5:0] ad, logic [31:0] wd); op(s, 1, 0, ad, wd); endtask
  task automatic rd(int s, logic [5:0] ad); op(s, 0, 1, ad, '0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nfail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) tick("R1");
    rst_n = 1'b1;
    repeat (3) tick("R1");
    // R1: reset state through status and control reads on both sides
    rd(0, STAT); rd(1, STAT); tick("R1");
    rd(0, CTRL); rd(1, CTRL); tick("R1");
    // R2 / R3: writes land in the remote receive slots
    wr(0, txa(0), 32'h1111_0000); tick("R3");
    wr(0, txa(3), 32'h3333_0003); tick("R3");
    rd(0, STAT); rd(1, STAT); tick("R2");
    // R5: second write into a full slot is dropped
    wr(0, txa(1), 32'hAAAA_0001); tick("R5");
    wr(0, txa(1), 32'hBBBB_0001); tick("R5");
    rd(1, rxa(1)); tick("R5");
    // R4: reads return data and release the slot
    rd(1, rxa(0)); tick("R4");
    rd(1, rxa(3)); tick("R4");
    rd(0, STAT); rd(1, STAT); tick("R4");
    rd(1, rxa(3)); tick("R4");
    // R13: transmit and unmapped addresses read as zero
    rd(0, txa(2)); rd(1, 6'h3C); tick("R13");
    rd(0, 6'h28); rd(1, 6'h0E); tick("R13");
    // R10: receive-full interrupt, channel 0 at bit 27 and channel 2 at bit 25
    wr(1, CTRL, 32'h0A00_0000); tick("R10");
    rd(1, CTRL); tick("R10");
    wr(0, txa(0), 32'hC0C0_0000); tick("R10");
    tick("R10");
    rd(1, rxa(0)); tick("R10");
    wr(0, txa(2), 32'hC2C2_0002); tick("R10");
    tick("R10");
    wr(0, txa(1), 32'hC1C1_0001); rd(1, rxa(2)); tick("R10");
    rd(1, STAT); tick("R10");
    rd(1, rxa(1)); tick("R10");
    // R6 / R11: doorbell A to B with its interrupt enabled on B
    wr(1, CTRL, 32'h8000_0000); tick("R11");
    wr(0, CTRL, 32'h0008_0000); tick("R6");
    rd(0, CTRL); rd(1, STAT); tick("R6");
    rd(0, CTRL); rd(1, STAT); tick("R11");
    // R7: ring again while pending still set
    wr(0, CTRL, 32'h0008_0000); tick("R7");
    repeat (3) begin rd(0, CTRL); rd(1, STAT); tick("R7"); end
    // R9: writing request as 0 leaves it outstanding
    wr(0, CTRL, 32'h0000_0000); tick("R9");
    rd(0, CTRL); tick("R9");
    // R8: zero write keeps pending, one write clears it, held request then moves
    wr(1, STAT, 32'h7FFF_FFFF); tick("R8");
    rd(1, STAT); tick("R8");
    wr(1, STAT, 32'h8000_0000); tick("R8");
    rd(1, STAT); rd(0, CTRL); tick("R8");
    rd(1, STAT); rd(0, CTRL); tick("R7");
    wr(1, STAT, 32'h8000_0000); tick("R8");
    rd(1, STAT); tick("R8");
    // R12: B to A data and doorbell
    wr(0, CTRL, 32'h8200_0000); tick("R12");
    wr(1, txa(1), 32'hB1B1_0001); tick("R12");
    rd(0, STAT); rd(1, STAT); tick("R12");
    rd(0, rxa(1)); tick("R12");
    wr(1, CTRL, 32'h0008_0000); tick("R12");
    rd(0, STAT); rd(1, CTRL); tick("R12");
    wr(0, STAT, 32'h8000_0000); tick("R12");
    rd(0, STAT); tick("R12");
    // Mixed traffic on both sides at once, all requirements
    for (int n = 0; n < 600; n++) begin
      for (int s = 0; s < 2; s++) begin
        int k = $urandom_range(0, 7);
        int c = $urandom_range(0, 3);
        logic [31:0] d = $urandom;
        case (k)
          0, 1: wr(s, txa(c), d);
          2, 3: rd(s, rxa(c));
          4: rd(s, STAT);
          5: rd(s, CTRL);
          6: wr(s, CTRL, d);
          default: wr(s, STAT, d);
        endcase
      end
      tick("R12");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nfail);
    $finish;
  end
endmodule